// File: doc/BRIEF.md
# Bufferless Deflection-Routed Cylindrical Packet Fabric

This block is a slot-accurate model of a 12-port packet switch. It holds no packet queues. The switch is built from 36 identical two-input, two-output routing nodes. The nodes sit in three concentric stages, and each stage is a ring of 3 angles by 4 heights. Every clock is one slot. In each slot, every node holds at most one packet: a valid flag, a 4-bit destination and a payload word. At the clock edge it forwards that packet one angle further. The packet either moves inward to the next stage at the same height, or stays in its stage and moves to a new height.

Packets enter the outermost stage through 12 input ports and leave the innermost stage through 12 output ports. Each outer stage resolves one height bit of the destination. The innermost stage lets packets travel round the angles until the angle field matches. Two packets never collide because of two mechanisms. An inner node that is about to receive a circulating packet stops the outer node that would feed it. Each input port also reports when its entry node is about to be taken, so that the traffic source can hold its packet and offer it again later.

Top module: `dv_fabric`

## Requirements
- R1: While reset is high, and in the first slot after a reset edge, no output port is valid and no input port reports busy.
- R2: A destination is encoded as {height[HB-1:0], angle[AB-1:0]}. Input port p = h*ANGLES + a feeds the outer node at angle a and height h. Output port q = h*ANGLES + a emits only packets whose destination is {h, a}.
- R3: A packet moves exactly one hop per slot. On stage c (not the innermost), the node compares destination bit AW-1-c with its height bit HB-1-c. On a match, and when not blocked, the packet moves to stage c+1 at the same height and the next angle, modulo ANGLES. Otherwise it stays on stage c at the next angle, with height bit HB-1-c inverted. Bits that a packet has already matched never change once it has moved inward.
- R4: On the innermost stage, a packet keeps its height and advances one angle per slot until the node angle equals the destination angle field. The packet is then registered onto that node's output port in the following slot.
- R5: A matching packet on stage c stays on stage c, and is deflected, whenever the node on stage c+1 that feeds the same target is sending its packet round its own stage in that slot. No node ever receives two packets in one slot.
- R6: in_busy[p] is high exactly when a circulating packet will occupy the entry node of port p in the next slot. An input packet offered while busy is dropped and never appears at any output. One offered while not busy is accepted.
- R7: Every accepted packet leaves exactly once, with its destination and payload unchanged. No packet is lost or duplicated, and the number of occupied nodes changes only by the number of acceptances and ejections.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Slot clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | PORTS | Packet offered on each input port |
| in_addr | input | PORTS*AW | Destination of each offered packet, port p at bits [p*AW +: AW] |
| in_data | input | PORTS*DATA_W | Payload of each offered packet |
| in_busy | output | PORTS | Entry node will be taken by a circulating packet; the offer is refused |
| out_valid | output | PORTS | Packet ejected on each output port (registered) |
| out_addr | output | PORTS*AW | Destination of each ejected packet |
| out_data | output | PORTS*DATA_W | Payload of each ejected packet |

## Verification
The embedded properties check several things on every cycle. No node ever receives a circulating packet and an inward packet together. A packet on an inner stage always carries the height prefix of that stage. Each output carries only its own destination. A busy input is always followed by an occupied entry node. The total node occupancy moves only by acceptances minus ejections. Only the bench scenarios can show the exact number of slots a packet spends on its route. They also show that a blocked packet takes the longer deflected path, that a refused offer never reaches an output, and that every accepted payload under mixed random load arrives exactly once.

// File: rtl/dv_pkg.sv
package dv_pkg;

  // Flat index of a node at (stage, angle, height).
  function automatic int node_idx(input int c, input int a, input int h,
                                  input int n_ang, input int n_hgt);
    return (c * n_ang + a) * n_hgt + h;
  endfunction

  // Angle that feeds angle a (ring predecessor).
  function automatic int prev_ang(input int a, input int n_ang);
    return (a + n_ang - 1) % n_ang;
  endfunction

  // Height reached by an intra-stage hop on stage c; identity on the innermost stage.
  function automatic int cross_h(input int c, input int h, input int hb);
    if (c >= hb) return h;
    return h ^ (1 << (hb - 1 - c));
  endfunction

endpackage

// File: rtl/dv_node.sv
module dv_node #(
  parameter int AW     = 4,
  parameter int DW     = 16,
  parameter int HB     = 2,
  parameter int AB     = 2,
  parameter int STAGES = 3,
  parameter int STAGE  = 0,
  parameter int ANGLE  = 0,
  parameter int HEIGHT = 0
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          w_v,
  input  logic [AW-1:0] w_addr,
  input  logic [DW-1:0] w_data,
  input  logic          n_v,
  input  logic [AW-1:0] n_addr,
  input  logic [DW-1:0] n_data,
  input  logic          blk,
  output logic          e_v,
  output logic [AW-1:0] e_addr,
  output logic [DW-1:0] e_data,
  output logic          s_v,
  output logic [AW-1:0] s_addr,
  output logic [DW-1:0] s_data,
  output logic          occ
);

  localparam bit            INNER = (STAGE == STAGES - 1);
  localparam logic [HB-1:0] HGT_V = HEIGHT[HB-1:0];
  localparam logic [AB-1:0] ANG_V = ANGLE[AB-1:0];

  logic          cur_v;
  logic [AW-1:0] cur_addr;
  logic [DW-1:0] cur_data;
  logic          hit;
  logic          go_in;

  // Slot register: the circulating arrival takes precedence; the two never coincide.
  always_ff @(posedge clk) begin
    if (rst) begin
      cur_v    <= 1'b0;
      cur_addr <= '0;
      cur_data <= '0;
    end else begin
      cur_v <= w_v | n_v;
      if (w_v) begin
        cur_addr <= w_addr;
        cur_data <= w_data;
      end else begin
        cur_addr <= n_addr;
        cur_data <= n_data;
      end
    end
  end

  generate
    if (INNER) begin : g_ang
      assign hit = (cur_addr[AB-1:0] == ANG_V);
    end else begin : g_bit
      assign hit = (cur_addr[AW-1-STAGE] == HGT_V[HB-1-STAGE]);
    end
  endgenerate

  assign go_in  = cur_v & hit & ~blk;
  assign s_v    = go_in;
  assign e_v    = cur_v & ~go_in;
  assign s_addr = cur_addr;
  assign s_data = cur_data;
  assign e_addr = cur_addr;
  assign e_data = cur_data;
  assign occ    = cur_v;

  // R5
  no_collide_chk: assert property (@(posedge clk) disable iff (rst) !(w_v && n_v));

  generate
    if (STAGE > 0) begin : g_pfx
      // R3
      prefix_chk: assert property (@(posedge clk) disable iff (rst)
        cur_v |-> (cur_addr[AW-1 -: STAGE] == HGT_V[HB-1 -: STAGE]));
    end
  endgenerate

endmodule

// File: rtl/dv_eject.sv
module dv_eject #(
  parameter int AW     = 4,
  parameter int DW     = 16,
  parameter int HB     = 2,
  parameter int AB     = 2,
  parameter int ANGLE  = 0,
  parameter int HEIGHT = 0
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          ej_v,
  input  logic [AW-1:0] ej_addr,
  input  logic [DW-1:0] ej_data,
  output logic          out_v,
  output logic [AW-1:0] out_addr,
  output logic [DW-1:0] out_data
);

  localparam logic [HB-1:0] HGT_V = HEIGHT[HB-1:0];
  localparam logic [AB-1:0] ANG_V = ANGLE[AB-1:0];

  always_ff @(posedge clk) begin
    if (rst) begin
      out_v    <= 1'b0;
      out_addr <= '0;
      out_data <= '0;
    end else begin
      out_v    <= ej_v;
      out_addr <= ej_addr;
      out_data <= ej_data;
    end
  end

  // R1
  rst_idle_chk: assert property (@(posedge clk) rst |=> !out_v);

  // R2
  out_port_chk: assert property (@(posedge clk) disable iff (rst)
    out_v |-> (out_addr == {HGT_V, ANG_V}));

endmodule

// File: rtl/dv_fabric.sv
module dv_fabric
  import dv_pkg::*;
#(
  parameter int ANGLES  = 3,
  parameter int HEIGHTS = 4,
  parameter int DATA_W  = 16,
  parameter int HB      = $clog2(HEIGHTS),
  parameter int AB      = $clog2(ANGLES),
  parameter int AW      = HB + AB,
  parameter int PORTS   = ANGLES * HEIGHTS
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic [PORTS-1:0]        in_valid,
  input  logic [PORTS*AW-1:0]     in_addr,
  input  logic [PORTS*DATA_W-1:0] in_data,
  output logic [PORTS-1:0]        in_busy,
  output logic [PORTS-1:0]        out_valid,
  output logic [PORTS*AW-1:0]     out_addr,
  output logic [PORTS*DATA_W-1:0] out_data
);

  localparam int STAGES = HB + 1;
  localparam int NODES  = STAGES * PORTS;

  logic              e_v    [NODES];
  logic [AW-1:0]     e_addr [NODES];
  logic [DATA_W-1:0] e_data [NODES];
  logic              s_v    [NODES];
  logic [AW-1:0]     s_addr [NODES];
  logic [DATA_W-1:0] s_data [NODES];
  logic [NODES-1:0]  occ;
  logic [PORTS-1:0]  acc;
  logic [PORTS-1:0]  ej;

  // Port edge: entry gating, busy reporting and registered ejection.
  generate
    for (genvar p = 0; p < PORTS; p++) begin : g_port
      localparam int PA  = p % ANGLES;
      localparam int PH  = p / ANGLES;
      localparam int SRC = node_idx(0, prev_ang(PA, ANGLES), cross_h(0, PH, HB), ANGLES, HEIGHTS);
      localparam int ENT = node_idx(0, PA, PH, ANGLES, HEIGHTS);
      localparam int OUT = node_idx(STAGES - 1, PA, PH, ANGLES, HEIGHTS);

      assign in_busy[p] = e_v[SRC];
      assign acc[p]     = in_valid[p] & ~e_v[SRC];
      assign ej[p]      = s_v[OUT];

      dv_eject #(
        .AW(AW), .DW(DATA_W), .HB(HB), .AB(AB), .ANGLE(PA), .HEIGHT(PH)
      ) u_ej (
        .clk     (clk),
        .rst     (rst),
        .ej_v    (s_v[OUT]),
        .ej_addr (s_addr[OUT]),
        .ej_data (s_data[OUT]),
        .out_v   (out_valid[p]),
        .out_addr(out_addr[p*AW +: AW]),
        .out_data(out_data[p*DATA_W +: DATA_W])
      );

      // R6
      busy_occ_chk: assert property (@(posedge clk) disable iff (rst)
        in_busy[p] |=> occ[ENT]);
    end
  endgenerate

  // Node grid with intra-stage crossing, inward links and block lines.
  generate
    for (genvar c = 0; c < STAGES; c++) begin : g_st
      for (genvar a = 0; a < ANGLES; a++) begin : g_an
        for (genvar h = 0; h < HEIGHTS; h++) begin : g_ht
          localparam int ME = node_idx(c, a, h, ANGLES, HEIGHTS);
          localparam int WS = node_idx(c, prev_ang(a, ANGLES), cross_h(c, h, HB), ANGLES, HEIGHTS);

          logic              nv;
          logic [AW-1:0]     na;
          logic [DATA_W-1:0] nd;
          logic              bk;

          if (c == 0) begin : g_inj
            localparam int P = h * ANGLES + a;
            assign nv = acc[P];
            assign na = in_addr[P*AW +: AW];
            assign nd = in_data[P*DATA_W +: DATA_W];
          end else begin : g_up
            localparam int NS = node_idx(c - 1, prev_ang(a, ANGLES), h, ANGLES, HEIGHTS);
            assign nv = s_v[NS];
            assign na = s_addr[NS];
            assign nd = s_data[NS];
          end

          if (c == STAGES - 1) begin : g_noblk
            assign bk = 1'b0;
          end else begin : g_blk
            localparam int BS = node_idx(c + 1, a, cross_h(c + 1, h, HB), ANGLES, HEIGHTS);
            assign bk = e_v[BS];
          end

          dv_node #(
            .AW(AW), .DW(DATA_W), .HB(HB), .AB(AB), .STAGES(STAGES),
            .STAGE(c), .ANGLE(a), .HEIGHT(h)
          ) u_nd (
            .clk   (clk),
            .rst   (rst),
            .w_v   (e_v[WS]),
            .w_addr(e_addr[WS]),
            .w_data(e_data[WS]),
            .n_v   (nv),
            .n_addr(na),
            .n_data(nd),
            .blk   (bk),
            .e_v   (e_v[ME]),
            .e_addr(e_addr[ME]),
            .e_data(e_data[ME]),
            .s_v   (s_v[ME]),
            .s_addr(s_addr[ME]),
            .s_data(s_data[ME]),
            .occ   (occ[ME])
          );
        end
      end
    end
  endgenerate

  // R7
  conserve_chk: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ($countones(occ) == $past($countones(occ)) + $past($countones(acc))
                                 - $past($countones(ej))));

endmodule

// File: tb/test_dv_fabric.sv
module test_dv_fabric;

  localparam int A  = 3;
  localparam int H  = 4;
  localparam int P  = A * H;
  localparam int HB = 2;
  localparam int AB = 2;
  localparam int AW = HB + AB;
  localparam int DW = 16;
  localparam int NS = HB + 1;
  localparam int MAXID = 4000;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic [P-1:0]      in_valid = '0;
  logic [P*AW-1:0]   in_addr  = '0;
  logic [P*DW-1:0]   in_data  = '0;
  logic [P-1:0]      in_busy;
  logic [P-1:0]      out_valid;
  logic [P*AW-1:0]   out_addr;
  logic [P*DW-1:0]   out_data;

  dv_fabric i_dv_fabric (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_addr(in_addr), .in_data(in_data),
    .in_busy(in_busy), .out_valid(out_valid), .out_addr(out_addr), .out_data(out_data)
  );

  always #10 clk = ~clk;

  int nchk = 0;
  int nfail = 0;
  int cyc = 0;
  int next_id = 1;
  int outstanding = 0;
  int st [MAXID];
  int ej_cyc [MAXID];
  logic [AW-1:0] exp_a [MAXID];

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Monitor: every ejection is checked for port, identity and uniqueness.
  always @(negedge clk) begin
    if (!rst) begin
      for (int q = 0; q < P; q++) begin
        if (out_valid[q]) begin
          int id;
          logic [AW-1:0] pa;
          id = int'(out_data[q*DW +: DW]);
          pa = AW'(((q / A) << AB) | (q % A));
          chk(out_addr[q*AW +: AW] == pa, "R2 output port vs destination",
              int'(out_addr[q*AW +: AW]), int'(pa));
          if (id < MAXID) begin
            chk(st[id] == 1, "R7 ejected packet was outstanding once", st[id], 1);
            chk(out_addr[q*AW +: AW] == exp_a[id], "R7 destination intact",
                int'(out_addr[q*AW +: AW]), int'(exp_a[id]));
            if (st[id] == 1) outstanding--;
            st[id] = 2;
            ej_cyc[id] = cyc;
          end else begin
            chk(1'b0, "R7 unknown payload", id, 0);
          end
        end
      end
    end
  end

  function automatic logic [AW-1:0] mk_addr(input int hh, input int aa);
    return AW'((hh << AB) | aa);
  endfunction

  // Uncontended hop count from node (c, a, h) to the ejecting node (R3, R4).
  function automatic int hops_from(input int c0, input int a0, input int h0, input logic [AW-1:0] d);
    int c = c0, a = a0, h = h0, n = 0;
    while (n < 64) begin
      if (c == NS - 1) begin
        if (a == int'(d[AB-1:0])) break;
      end else if (int'(d[AW-1-c]) == ((h >> (HB-1-c)) & 1)) begin
        c++;
      end else begin
        h = h ^ (1 << (HB-1-c));
      end
      a = (a + 1) % A;
      n++;
    end
    return n;
  endfunction

  task automatic offer(input int p, input int id, input logic [AW-1:0] d, input int mark);
    in_valid[p] = 1'b1;
    in_addr[p*AW +: AW] = d;
    in_data[p*DW +: DW] = DW'(id);
    st[id] = mark;
    exp_a[id] = d;
    if (mark == 1) outstanding++;
  endtask

  task automatic do_reset;
    rst = 1'b1;
    in_valid = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic t_reset;
    rst = 1'b1;
    repeat (2) @(negedge clk);
    // R1
    chk(out_valid == '0, "R1 outputs idle in reset", int'(out_valid), 0);
    chk(in_busy == '0, "R1 no busy in reset", int'(in_busy), 0);
    rst = 1'b0;
    @(negedge clk);
    chk(out_valid == '0, "R1 outputs idle after reset", int'(out_valid), 0);
    chk(in_busy == '0, "R1 no busy after reset", int'(in_busy), 0);
  endtask

  task automatic t_single;
    for (int p = 0; p < P; p++) begin
      int q = (p * 5 + 3) % P;
      int id = next_id++;
      int dc;
      logic [AW-1:0] d = mk_addr(q / A, q % A);
      @(negedge clk);
      dc = cyc;
      offer(p, id, d, 1);
      @(negedge clk);
      in_valid[p] = 1'b0;
      repeat (25) @(negedge clk);
      // R4
      chk(st[id] == 2, "R4 single packet ejected", st[id], 2);
      // R3
      chk(ej_cyc[id] == dc + hops_from(0, p % A, p / A, d) + 2, "R3 hop-per-slot latency",
          ej_cyc[id] - dc, hops_from(0, p % A, p / A, d) + 2);
    end
  endtask

  task automatic t_refuse;
    int ida = next_id++;
    int idb = next_id++;
    int dc;
    logic [AW-1:0] da = mk_addr(2, 0);
    @(negedge clk);
    dc = cyc;
    offer(0, ida, da, 1);
    @(negedge clk);
    in_valid[0] = 1'b0;
    // R6: the deflected packet now heads for the entry node of port 7
    chk(in_busy[7] == 1'b1, "R6 busy on occupied entry", int'(in_busy[7]), 1);
    chk($countones(in_busy) == 1, "R6 only one busy port", $countones(in_busy), 1);
    offer(7, idb, mk_addr(0, 0), 3);
    @(negedge clk);
    in_valid[7] = 1'b0;
    repeat (25) @(negedge clk);
    chk(st[ida] == 2, "R6 circulating packet delivered", st[ida], 2);
    chk(st[idb] == 3, "R6 refused packet never emerges", st[idb], 3);
    chk(ej_cyc[ida] == dc + hops_from(0, 0, 0, da) + 2, "R3 deflect-then-ingress latency",
        ej_cyc[ida] - dc, hops_from(0, 0, 0, da) + 2);
  endtask

  task automatic t_block;
    int idx = next_id++;
    int idy = next_id++;
    int dx, dy;
    logic [AW-1:0] ax = mk_addr(0, 2);
    logic [AW-1:0] ay = mk_addr(0, 0);
    @(negedge clk);
    dx = cyc;
    offer(5, idx, ax, 1);
    @(negedge clk);
    in_valid[5] = 1'b0;
    chk(in_busy[0] == 1'b0, "R6 port 0 free", int'(in_busy[0]), 0);
    dy = cyc;
    offer(0, idy, ay, 1);
    @(negedge clk);
    in_valid[0] = 1'b0;
    repeat (25) @(negedge clk);
    chk(st[idx] == 2 && st[idy] == 2, "R5 both contenders delivered", st[idx] + st[idy], 4);
    chk(ej_cyc[idx] == dx + hops_from(0, 2, 1, ax) + 2, "R5 circulating inner packet unaffected",
        ej_cyc[idx] - dx, hops_from(0, 2, 1, ax) + 2);
    // R5: Y is held on the outer stage, lands at angle 1 height 2, then continues
    chk(ej_cyc[idy] == dy + 1 + hops_from(0, 1, 2, ay) + 2, "R5 blocked packet deflected",
        ej_cyc[idy] - dy, 1 + hops_from(0, 1, 2, ay) + 2);
  endtask

  task automatic t_random;
    int sent = 0;
    for (int k = 0; k < 400; k++) begin
      @(negedge clk);
      for (int p = 0; p < P; p++) begin
        if (!in_busy[p] && $urandom_range(0, 99) < 30 && next_id < MAXID) begin
          offer(p, next_id, mk_addr($urandom_range(0, H-1), $urandom_range(0, A-1)), 1);
          next_id++;
          sent++;
        end else begin
          in_valid[p] = 1'b0;
        end
      end
    end
    @(negedge clk);
    in_valid = '0;
    for (int k = 0; k < 4000 && outstanding > 0; k++) @(negedge clk);
    repeat (4) @(negedge clk);
    // R7
    chk(outstanding == 0, "R7 all random packets delivered", outstanding, 0);
    chk(sent > 100, "R7 random load applied", sent, 101);
    chk(out_valid == '0, "R7 no stray output after drain", int'(out_valid), 0);
  endtask

  initial begin
    for (int i = 0; i < MAXID; i++) begin
      st[i] = 0;
      ej_cyc[i] = 0;
      exp_a[i] = '0;
    end
    t_reset;
    t_single;
    do_reset;
    t_refuse;
    do_reset;
    t_block;
    do_reset;
    t_random;
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

  initial begin
    #(20 * 150000);
    nchk++;
    nfail++;
    $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

endmodule